// File: doc/BRIEF.md
# Indirect Bit Read-Modify-Write Unit

This execution unit performs single-bit operations on a memory byte for an 8-bit microcontroller core. A two-byte opcode arrives with a start strobe. The upper opcode byte names the 8-bit register whose low three bits select the bit position, so the bit is chosen at run time. The lower byte names the operation and one of two 16-bit pointer pairs, which supplies the byte address.

The unit reads the byte and changes the addressed bit. It can set the bit, clear it, invert it, load the carry flag into it, or copy the bit into carry. It writes the byte back when the operation changes memory. At the end it raises one-cycle write enables and values for the jump, zero and carry flags, a done pulse, and the number of cycles the operation took.

Register and pointer values are read combinationally in the start cycle. Memory answers a read in the same cycle as the read strobe.

Top module: `bit_rmw_unit`

## Requirements
- R1: An opcode whose upper byte is not `11101ggg`, or whose lower byte (bits 7:1) is not one of the five encodings in R3, R4, R5, R7 and R8, raises `illegal` for one cycle on the edge after start. It causes no memory write and no flag write, and the unit stays idle.
- R2: In the start cycle `rf_sel` equals opcode bits 2:0 of the upper byte, and the bit position is `rf_data[2:0]`. `pair_sel` is 2 when lower-byte bit 0 is 0 and 3 when it is 1. The memory read address is `pair_data` as sampled in the start cycle.
- R3: Lower byte `1000_001x` sets the addressed bit.
- R4: Lower byte `1000_101x` clears the addressed bit.
- R5: Lower byte `1001_001x` inverts the addressed bit.
- R6: For the operations of R3, R4 and R5, the jump and zero flags are both written. Both are 1 when the addressed bit was 0 before the operation and 0 when it was 1. Carry is not written.
- R7: Lower byte `1001_101x` stores `cf_in` into the addressed bit. It writes the jump flag as 1 and writes neither zero nor carry.
- R8: Lower byte `1001_111x` writes carry with the addressed bit and writes jump with its inverse. It leaves zero unwritten and performs no memory write.
- R9: `latch_read` is high during the memory read exactly for the operations of R4 and R5.
- R10: Counting the start cycle as 1, `done` is high for one cycle in cycle 4 for R8 and cycle 5 otherwise, and `cycles` shows that number while `done` is high.
- R11: The write uses the read address, and the written byte differs from the byte read in at most one bit.
- R12: A start strobe while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_hi | input | 8 | Upper opcode byte |
| op_lo | input | 8 | Lower opcode byte |
| busy | output | 1 | Operation in progress |
| rf_sel | output | 3 | 8-bit register index for the bit position |
| rf_data | input | 8 | Selected register value |
| pair_sel | output | 2 | Pointer pair index |
| pair_data | input | 16 | Selected pointer value |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid with `mem_rd` |
| latch_read | output | 1 | Ask mapped ports to return output latches |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| cf_in | input | 1 | Current carry flag |
| jf_we | output | 1 | Jump flag write enable |
| jf_val | output | 1 | Jump flag value |
| zf_we | output | 1 | Zero flag write enable |
| zf_val | output | 1 | Zero flag value |
| cf_we | output | 1 | Carry flag write enable |
| cf_val | output | 1 | Carry flag value |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 4 | Cycle count, valid with `done` |
| illegal | output | 1 | One-cycle illegal opcode pulse |

## Verification
The hardest case to reach from the ports is a second start strobe arriving while an operation is in flight. That strobe must leave no trace in memory, in the flag outputs or in the timing. The bench holds start high with a different, valid opcode during the read cycle of a running operation. It then checks that the byte shows only the first operation, that exactly one done pulse arrives in the expected cycle, and that the unit is idle right afterwards. Cases where a write leaves the byte unchanged are also driven: clearing a bit that is already 0, and reading a bit into carry. These confirm that the flags follow the old bit value and not a detected change.

// File: rtl/bit_rmw_pkg.sv
package bit_rmw_pkg;

  localparam int BYTE_W = 8;
  localparam int POS_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    BOP_SET, BOP_CLR, BOP_TOG, BOP_PUT, BOP_GET, BOP_BAD
  } bop_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MOD, ST_WRITE, ST_DONE
  } st_e;

  // flag vectors are ordered {jump, zero, carry}
  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic [2:0]        we;
    logic [2:0]        val;
  } bit_res_t;

  function automatic bop_e bop_decode(input logic [7:0] hi, input logic [7:0] lo);
    bop_e r;
    if (hi[7:3] != 5'b11101) r = BOP_BAD;
    else begin
      case (lo[7:1])
        7'b1000_001: r = BOP_SET;
        7'b1000_101: r = BOP_CLR;
        7'b1001_001: r = BOP_TOG;
        7'b1001_101: r = BOP_PUT;
        7'b1001_111: r = BOP_GET;
        default:     r = BOP_BAD;
      endcase
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pos_mask(input logic [POS_W-1:0] pos);
    return BYTE_W'(1) << pos;
  endfunction

  function automatic bit_res_t bit_update(input bop_e op, input logic [BYTE_W-1:0] din,
                                          input logic [POS_W-1:0] pos, input logic cf);
    bit_res_t r;
    logic [BYTE_W-1:0] m;
    logic old;
    m   = pos_mask(pos);
    old = |(din & m);
    r.data = din;
    r.we   = 3'b000;
    r.val  = 3'b000;
    case (op)
      BOP_SET: begin r.data = din | m;  r.we = 3'b110; r.val = {~old, ~old, 1'b0}; end
      BOP_CLR: begin r.data = din & ~m; r.we = 3'b110; r.val = {~old, ~old, 1'b0}; end
      BOP_TOG: begin r.data = din ^ m;  r.we = 3'b110; r.val = {~old, ~old, 1'b0}; end
      BOP_PUT: begin
        r.data = cf ? (din | m) : (din & ~m);
        r.we   = 3'b100;
        r.val  = 3'b100;
      end
      BOP_GET: begin r.we = 3'b101; r.val = {~old, 1'b0, old}; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] op_cycles(input bop_e op);
    return (op == BOP_GET) ? 4'd4 : 4'd5;
  endfunction

  function automatic logic wants_latch(input bop_e op);
    return (op == BOP_CLR) || (op == BOP_TOG);
  endfunction

endpackage

// File: rtl/bit_rmw_decode.sv
module bit_rmw_decode
  import bit_rmw_pkg::*;
(
  input  logic [7:0] op_hi,
  input  logic [7:0] op_lo,
  output bop_e       bop,
  output logic       bad,
  output logic [2:0] reg_idx,
  output logic [1:0] pair_idx
);
  always_comb begin
    bop      = bop_decode(op_hi, op_lo);
    bad      = (bop == BOP_BAD);
    reg_idx  = op_hi[2:0];
    pair_idx = {1'b1, op_lo[0]};   // 2 or 3
  end
endmodule

// File: rtl/bit_rmw_alu.sv
module bit_rmw_alu
  import bit_rmw_pkg::*;
(
  input  bop_e              op,
  input  logic [BYTE_W-1:0] din,
  input  logic [POS_W-1:0]  pos,
  input  logic              cf,
  output bit_res_t          res
);
  always_comb res = bit_update(op, din, pos, cf);
endmodule

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit
  import bit_rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op_hi,
  input  logic [7:0]        op_lo,
  output logic              busy,
  output logic [2:0]        rf_sel,
  input  logic [BYTE_W-1:0] rf_data,
  output logic [1:0]        pair_sel,
  input  logic [ADDR_W-1:0] pair_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              latch_read,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              cf_in,
  output logic              jf_we,
  output logic              jf_val,
  output logic              zf_we,
  output logic              zf_val,
  output logic              cf_we,
  output logic              cf_val,
  output logic              done,
  output logic [CNT_W-1:0]  cycles,
  output logic              illegal
);

  st_e                st_q;
  bop_e               dec_op;
  logic               dec_bad;
  bop_e               op_q;
  logic [POS_W-1:0]   pos_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BYTE_W-1:0]  rd_q;
  bit_res_t           alu_res;
  bit_res_t           res_q;
  logic               illegal_q;
  logic               accept;

  // checker-side observation registers
  logic [ADDR_W-1:0]  seen_rd_addr;
  logic [BYTE_W-1:0]  seen_rd_byte;
  logic [CNT_W-1:0]   cyc_cnt;

  bit_rmw_decode u_dec (
    .op_hi   (op_hi),
    .op_lo   (op_lo),
    .bop     (dec_op),
    .bad     (dec_bad),
    .reg_idx (rf_sel),
    .pair_idx(pair_sel)
  );

  bit_rmw_alu u_alu (
    .op  (op_q),
    .din (rd_q),
    .pos (pos_q),
    .cf  (cf_in),
    .res (alu_res)
  );

  assign accept = (st_q == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= BOP_BAD;
      pos_q     <= '0;
      addr_q    <= '0;
      rd_q      <= '0;
      res_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && dec_bad;
      case (st_q)
        ST_IDLE: if (accept && !dec_bad) begin
          op_q   <= dec_op;
          pos_q  <= rf_data[POS_W-1:0];
          addr_q <= pair_data;
          st_q   <= ST_READ;
        end
        ST_READ: begin
          rd_q <= mem_rdata;
          st_q <= ST_MOD;
        end
        ST_MOD: begin
          res_q <= alu_res;
          st_q  <= (op_q == BOP_GET) ? ST_DONE : ST_WRITE;
        end
        ST_WRITE: st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (st_q != ST_IDLE);
    mem_addr   = addr_q;
    mem_rd     = (st_q == ST_READ);
    mem_wr     = (st_q == ST_WRITE);
    mem_wdata  = res_q.data;
    latch_read = mem_rd && wants_latch(op_q);
    done       = (st_q == ST_DONE);
    jf_we      = done && res_q.we[2];
    zf_we      = done && res_q.we[1];
    cf_we      = done && res_q.we[0];
    jf_val     = res_q.val[2];
    zf_val     = res_q.val[1];
    cf_val     = res_q.val[0];
    cycles     = done ? CNT_W'(op_cycles(op_q)) : '0;
    illegal    = illegal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_rd_addr <= '0;
      seen_rd_byte <= '0;
      cyc_cnt      <= '0;
    end else begin
      if (mem_rd) begin
        seen_rd_addr <= mem_addr;
        seen_rd_byte <= mem_rdata;
      end
      if (accept && !dec_bad) cyc_cnt <= CNT_W'(2);
      else if (busy)          cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_wr && !jf_we && !zf_we && !cf_we && !busy));

  assert_zero_tracks_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zf_we |-> (jf_we && (jf_val == zf_val) && !cf_we));

  assert_put_forces_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == BOP_PUT) |-> (jf_we && jf_val && !zf_we && !cf_we));

  assert_get_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (op_q != BOP_GET));

  assert_latch_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_read |-> (mem_rd && (op_q == BOP_CLR || op_q == BOP_TOG)));

  assert_cycle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles == cyc_cnt));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_write_one_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((mem_addr == seen_rd_addr) && ($countones(mem_wdata ^ seen_rd_byte) <= 1)));

endmodule

// File: tb/bit_rmw_unit_tb.sv
`timescale 1ns/1ps
module bit_rmw_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_hi = 8'h00, op_lo = 8'h00;
  logic        busy;
  logic [2:0]  rf_sel;
  logic [7:0]  rf_data;
  logic [1:0]  pair_sel;
  logic [15:0] pair_data;
  logic [15:0] mem_addr;
  logic        mem_rd, latch_read, mem_wr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        cf_in = 1'b0;
  logic        jf_we, jf_val, zf_we, zf_val, cf_we, cf_val;
  logic        done, illegal;
  logic [3:0]  cycles;

  always #2.5 clk = ~clk;

  bit_rmw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_hi(op_hi), .op_lo(op_lo),
    .busy(busy), .rf_sel(rf_sel), .rf_data(rf_data), .pair_sel(pair_sel),
    .pair_data(pair_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .latch_read(latch_read), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .cf_in(cf_in), .jf_we(jf_we), .jf_val(jf_val),
    .zf_we(zf_we), .zf_val(zf_val), .cf_we(cf_we), .cf_val(cf_val),
    .done(done), .cycles(cycles), .illegal(illegal)
  );

  localparam logic [15:0] PTR_DE = 16'h1234;
  localparam logic [15:0] PTR_HL = 16'hABCD;

  logic [7:0]  regs [8];
  logic [7:0]  mem  [256];
  int          wr_cnt = 0;
  logic [15:0] rd_addr_seen = '0;
  logic        latch_seen = 1'b0;

  assign rf_data   = regs[rf_sel];
  assign pair_data = (pair_sel == 2'd3) ? PTR_HL : ((pair_sel == 2'd2) ? PTR_DE : 16'h0000);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) begin
      rd_addr_seen <= mem_addr;
      latch_seen   <= latch_read;
    end
  end

  // {op_lo, g, reg value, byte before, cf, byte after, we{j,z,c}, val{j,z,c}, cycles}
  typedef logic [45:0] vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    {8'h82, 3'd1, 8'h0B, 8'h00, 1'b0, 8'h08, 3'b110, 3'b110, 4'd5},
    {8'h83, 3'd2, 8'hF7, 8'h80, 1'b1, 8'h80, 3'b110, 3'b000, 4'd5},
    {8'h8A, 3'd3, 8'h00, 8'hFF, 1'b0, 8'hFE, 3'b110, 3'b000, 4'd5},
    {8'h8B, 3'd4, 8'h05, 8'h00, 1'b1, 8'h00, 3'b110, 3'b110, 4'd5},
    {8'h92, 3'd5, 8'h02, 8'h55, 1'b0, 8'h51, 3'b110, 3'b000, 4'd5},
    {8'h93, 3'd6, 8'h0E, 8'h00, 1'b0, 8'h40, 3'b110, 3'b110, 4'd5},
    {8'h9A, 3'd7, 8'h04, 8'h00, 1'b1, 8'h10, 3'b100, 3'b100, 4'd5},
    {8'h9B, 3'd0, 8'h01, 8'hFF, 1'b0, 8'hFD, 3'b100, 3'b100, 4'd5},
    {8'h9E, 3'd1, 8'h06, 8'h40, 1'b0, 8'h40, 3'b101, 3'b001, 4'd4},
    {8'h9F, 3'd2, 8'h03, 8'hF7, 1'b1, 8'hF7, 3'b101, 3'b100, 4'd4}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] lo);
    case (lo[7:1])
      7'h41:   return "R3";
      7'h45:   return "R4";
      7'h49:   return "R5";
      7'h4D:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // issue one operation and return the cycle (start = 1) in which done was seen
  task automatic launch(input logic [7:0] hi, input logic [7:0] lo, output int k);
    @(negedge clk);
    op_hi = hi; op_lo = lo; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 2;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("reset busy", 32'(busy), 0);
    chk("reset done", 32'(done), 0);
    chk("reset mem_wr", 32'(mem_wr), 0);
    chk("reset illegal", 32'(illegal), 0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t        t;
      logic [7:0]  lo;
      logic [15:0] ptr;
      int          k;
      int          w0;
      string       rq;
      t   = VECS[v];
      lo  = t[45:38];
      ptr = lo[0] ? PTR_HL : PTR_DE;
      rq  = req_of(lo);
      regs[t[37:35]] = t[34:27];
      mem[ptr[7:0]]  = t[26:19];
      cf_in = t[18];
      w0 = wr_cnt;
      launch({5'b11101, t[37:35]}, lo, k);
      chk("R10 done cycle", 32'(k), 32'(t[3:0]));
      chk("R10 cycles port", 32'(cycles), 32'(t[3:0]));
      chk({rq, " byte"}, 32'(mem[ptr[7:0]]), 32'(t[17:10]));
      chk({rq, " R6 flag enables"}, 32'({jf_we, zf_we, cf_we}), 32'(t[9:7]));
      chk({rq, " R6 flag values"}, 32'({jf_val, zf_val, cf_val} & t[9:7]), 32'(t[6:4]));
      chk("R2 read address", 32'(rd_addr_seen), 32'(ptr));
      chk("R9 latch select", 32'(latch_seen), 32'(lo[7:1] == 7'h45 || lo[7:1] == 7'h49));
      chk("R8 R11 write count", 32'(wr_cnt - w0), (lo[7:1] == 7'h4F) ? 0 : 1);
      @(negedge clk);
      chk("R10 done one cycle", 32'(done), 0);
    end

    // R1: unknown lower byte
    begin
      int w0;
      w0 = wr_cnt;
      mem[PTR_DE[7:0]] = 8'h3C;
      @(negedge clk);
      op_hi = 8'hE9; op_lo = 8'h84; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 illegal lower byte", 32'(illegal), 1);
      chk("R1 stays idle", 32'(busy), 0);
      chk("R1 no flag write", 32'({jf_we, zf_we, cf_we}), 0);
      @(negedge clk);
      chk("R1 pulse one cycle", 32'(illegal), 0);
      // R1: wrong upper byte with a valid lower byte
      op_hi = 8'hC1; op_lo = 8'h82; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 illegal upper byte", 32'(illegal), 1);
      repeat (6) @(negedge clk);
      chk("R1 no memory write", 32'(wr_cnt - w0), 0);
      chk("R1 byte intact", 32'(mem[PTR_DE[7:0]]), 32'h3C);
    end

    // R12: second start while busy is ignored
    begin
      int k;
      regs[1] = 8'h0B;
      mem[PTR_DE[7:0]] = 8'h00;
      @(negedge clk);
      op_hi = 8'hE9; op_lo = 8'h82; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_lo = 8'h92;          // still start, different valid op, during read
      @(negedge clk);
      start = 1'b0;
      k = 3;
      while (!done && k < 20) begin
        @(negedge clk);
        k++;
      end
      chk("R12 done cycle", 32'(k), 5);
      chk("R12 byte from first op", 32'(mem[PTR_DE[7:0]]), 32'h08);
      @(negedge clk);
      chk("R12 idle after done", 32'(busy), 0);
      chk("R12 no second done", 32'(done), 0);
    end

    finish_run();
  end

endmodule